// File: doc/BRIEF.md
# Quadrature Binary Reference Generator

This block produces a pair of 1-bit periodic reference streams, sine and cosine, with the cosine a quarter period ahead of the sine. It uses them to multiply a signed sample by plus or minus one. Once the high-frequency part is filtered off, each stream approximates a sinusoid at the clock rate divided by 256. A full period is never stored. Only a 64-entry base pattern exists, and each address is mapped onto it by folding. The second quarter reads the pattern backwards. The second half reads the first half again with every bit inverted. This gives odd half-wave symmetry.

The address state is kept in a Gray-code counter, so exactly one state bit toggles per step. A small control stage turns the address into a per-channel selection, made of a pattern index, a reverse flag and an invert flag. A datapath stage reads the pattern and applies the selection. It then steers either the incoming sample or its two's-complement negation onto each product output. This select is the exact digital form of multiplying by the reference. The base pattern comes from a parameter by default. A build parameter can switch the source to an input port instead.

Top module: `quadRefGen`

## Requirements
- R1: While a synchronous reset is sampled high, the next clock edge sets `addr` to 0 and `wrapStrobe` to 0.
- R2: On every rising edge with `en` high and reset low, `addr` advances by one, modulo 256.
- R3: On an edge with `en` low, `addr` is unchanged, so `sinBit`, `cosBit` and the product outputs stay stable for a fixed sample.
- R4: `wrapStrobe` is high for exactly the one cycle in which `addr` reads 0 after an enabled step from 255. It is low in every other cycle, including while the count is held.
- R5: For address a, `sinBit` = P[i] XOR a[7]. Here P is the 64-bit base pattern (bit 0 = index 0) and i = a[5:0] when a[6] is 0, or the bitwise complement of a[5:0] when a[6] is 1.
- R6: `cosBit` at address a equals the R5 sine value at address (a + 64) mod 256.
- R7: Every full period of 256 steps holds exactly 128 ones on each output, for any pattern. With the default pattern, the first 64 steps of the sine output hold exactly 11 zeros.
- R8: `sinProd` equals `sampleIn` when `sinBit` is 1 and its two's-complement negation modulo 2^SampleW when it is 0. The most negative value therefore maps to itself. `cosProd` follows the same rule with `cosBit`.
- R9: With `UsePortPattern` = 1, the pattern P is taken from `patternIn` instead of the `BasePattern` parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Step enable; the count holds while low |
| patternIn | input | 64 | Base pattern, used only when UsePortPattern = 1 |
| sampleIn | input | SampleW | Signed sample to be multiplied by the references |
| sinBit | output | 1 | Sine reference bit |
| cosBit | output | 1 | Cosine reference bit |
| addr | output | 8 | Current sequence address, binary |
| wrapStrobe | output | 1 | One-cycle pulse after wrapping from 255 to 0 |
| sinProd | output | SampleW | Sample times the sine reference (±1) |
| cosProd | output | SampleW | Sample times the cosine reference (±1) |

## Verification
The bench sweeps a whole period on two instances, one on the default pattern and one on a port pattern. At every address it compares both bits with a folding model. An off-by-one in the reversal, which uses complement rather than 63 minus the index, or a quarter-offset error in the cosine shows up as mismatches near the quarter boundaries. The bench also counts ones per period, which catches an inversion tied to the wrong address bit.

It parks the count at 255 with the enable low, to expose a strobe that fires on address value instead of on the wrap step. It also feeds the most negative sample, to catch a negation that saturates or widens instead of wrapping.

// File: rtl/qrg_pkg.sv
`timescale 1ns/1ps
package qrg_pkg;
  // Address width of one full period; the base pattern covers one quarter.
  localparam int ADDR_W   = 8;
  localparam int IDX_W    = ADDR_W - 2;
  localparam int BASE_LEN = 1 << IDX_W;

  // Per-channel fold selection: invert flag, reverse flag, quarter index.
  typedef struct packed {
    logic             inv;
    logic             rev;
    logic [IDX_W-1:0] idx;
  } seqSel_t;

  // Strobes from control to datapath.
  typedef struct packed {
    seqSel_t sinSel;
    seqSel_t cosSel;
  } qrgStrobes_t;
endpackage

// File: rtl/qrgCtrl.sv
`timescale 1ns/1ps
module qrgCtrl
  import qrg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  output logic [ADDR_W-1:0] addrBin,
  output logic              wrapStrobe,
  output qrgStrobes_t       strobes
);
  localparam logic [ADDR_W-1:0] QuarterStep = ADDR_W'(BASE_LEN);

  logic [ADDR_W-1:0] grayQ;
  logic [ADDR_W-1:0] grayNext;
  logic [ADDR_W-1:0] binNow;
  logic [ADDR_W-1:0] binNext;
  logic [ADDR_W-1:0] cosAddr;
  logic              wrapQ;

  // Gray to binary: prefix XOR from the top bit down.
  always_comb begin
    binNow[ADDR_W-1] = grayQ[ADDR_W-1];
    for (int b = ADDR_W-2; b >= 0; b--) begin
      binNow[b] = binNow[b+1] ^ grayQ[b];
    end
  end

  assign binNext  = binNow + 1'b1;
  assign grayNext = binNext ^ (binNext >> 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      grayQ <= '0;
      wrapQ <= 1'b0;
    end else begin
      if (en) grayQ <= grayNext;
      wrapQ <= en && (&binNow);
    end
  end

  function automatic seqSel_t mkSel(logic [ADDR_W-1:0] a);
    seqSel_t s;
    s.inv = a[ADDR_W-1];
    s.rev = a[ADDR_W-2];
    s.idx = a[IDX_W-1:0];
    return s;
  endfunction

  assign cosAddr        = binNow + QuarterStep;
  assign strobes.sinSel = mkSel(binNow);
  assign strobes.cosSel = mkSel(cosAddr);
  assign addrBin        = binNow;
  assign wrapStrobe     = wrapQ;

  // R2
  gray_step_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> ($countones(grayQ ^ $past(grayQ)) == 1));

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> (addrBin == ADDR_W'($past(addrBin) + 1'b1)));

  // R3
  hold_state_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(grayQ));

  // R4
  wrap_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    wrapStrobe |-> (addrBin == '0));

  // R4
  wrap_single_chk: assert property (@(posedge clk) disable iff (rst)
    wrapStrobe |=> !wrapStrobe);
endmodule

// File: rtl/qrgPath.sv
`timescale 1ns/1ps
module qrgPath
  import qrg_pkg::*;
#(
  parameter int SampleW = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [BASE_LEN-1:0]       pattern,
  input  qrgStrobes_t               strobes,
  input  logic signed [SampleW-1:0] sampleIn,
  output logic                      sinBit,
  output logic                      cosBit,
  output logic signed [SampleW-1:0] sinProd,
  output logic signed [SampleW-1:0] cosProd
);
  localparam int NumCh = 2;

  seqSel_t                   chSel  [NumCh];
  logic                      chBit  [NumCh];
  logic signed [SampleW-1:0] chProd [NumCh];
  logic signed [SampleW-1:0] negSample;

  assign chSel[0]  = strobes.sinSel;
  assign chSel[1]  = strobes.cosSel;
  assign negSample = SampleW'(-sampleIn);

  for (genvar ch = 0; ch < NumCh; ch++) begin : g_ch
    logic [IDX_W-1:0] foldIdx;
    assign foldIdx    = chSel[ch].rev ? ~chSel[ch].idx : chSel[ch].idx;
    assign chBit[ch]  = pattern[foldIdx] ^ chSel[ch].inv;
    assign chProd[ch] = chBit[ch] ? sampleIn : negSample;
  end

  assign sinBit  = chBit[0];
  assign cosBit  = chBit[1];
  assign sinProd = chProd[0];
  assign cosProd = chProd[1];

  // R8
  prod_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (sinBit == cosBit) ? (sinProd == cosProd)
                       : (sinProd == SampleW'(-cosProd)));
endmodule

// File: rtl/quadRefGen.sv
`timescale 1ns/1ps
module quadRefGen
  import qrg_pkg::*;
#(
  parameter int              SampleW        = 16,
  parameter bit              UsePortPattern = 1'b0,
  parameter logic [BASE_LEN-1:0] BasePattern = 64'hFFFF_FFFF_FEF7_6D50
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic [BASE_LEN-1:0]       patternIn,
  input  logic signed [SampleW-1:0] sampleIn,
  output logic                      sinBit,
  output logic                      cosBit,
  output logic [ADDR_W-1:0]         addr,
  output logic                      wrapStrobe,
  output logic signed [SampleW-1:0] sinProd,
  output logic signed [SampleW-1:0] cosProd
);
  logic [BASE_LEN-1:0] activePat;
  qrgStrobes_t         strobes;

  if (UsePortPattern) begin : g_portPat
    assign activePat = patternIn;
  end else begin : g_paramPat
    logic unusedPatternIn;
    assign unusedPatternIn = ^patternIn;
    assign activePat       = BasePattern;
  end

  qrgCtrl ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .addrBin   (addr),
    .wrapStrobe(wrapStrobe),
    .strobes   (strobes)
  );

  qrgPath #(.SampleW(SampleW)) path_i (
    .clk     (clk),
    .rst     (rst),
    .pattern (activePat),
    .strobes (strobes),
    .sampleIn(sampleIn),
    .sinBit  (sinBit),
    .cosBit  (cosBit),
    .sinProd (sinProd),
    .cosProd (cosProd)
  );
endmodule

// File: tb/quadRefGen_tb_top.sv
`timescale 1ns/1ps
module quadRefGen_tb_top;
  localparam logic [63:0] DefPat = 64'hFFFF_FFFF_FEF7_6D50;
  localparam logic [63:0] AltPat = 64'h0123_4567_89AB_CDEF;

  // Sign-select vectors: {sample, expected negation}
  localparam logic [31:0] VecTab [8] = '{
    {16'h0000, 16'h0000}, {16'h0001, 16'hFFFF}, {16'h7FFF, 16'h8001},
    {16'h8000, 16'h8000}, {16'hFFFF, 16'h0001}, {16'h0064, 16'hFF9C},
    {16'h1234, 16'hEDCC}, {16'hC000, 16'h4000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic signed [15:0] sampleIn = '0;
  logic [63:0] patternIn = AltPat;

  logic sinBit, cosBit, wrapStrobe;
  logic [7:0] addr;
  logic signed [15:0] sinProd, cosProd;
  logic pSin, pCos, pWrap;
  logic [7:0] pAddr;
  logic signed [15:0] pSinProd, pCosProd;

  int nRun = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  quadRefGen dut_i (
    .clk(clk), .rst(rst), .en(en), .patternIn(patternIn), .sampleIn(sampleIn),
    .sinBit(sinBit), .cosBit(cosBit), .addr(addr), .wrapStrobe(wrapStrobe),
    .sinProd(sinProd), .cosProd(cosProd)
  );

  quadRefGen #(.UsePortPattern(1'b1)) dutPort_i (
    .clk(clk), .rst(rst), .en(en), .patternIn(patternIn), .sampleIn(sampleIn),
    .sinBit(pSin), .cosBit(pCos), .addr(pAddr), .wrapStrobe(pWrap),
    .sinProd(pSinProd), .cosProd(pCosProd)
  );

  function automatic logic refBit(logic [63:0] p, logic [7:0] a);
    logic [5:0] i;
    i = a[6] ? ~a[5:0] : a[5:0];
    return p[i] ^ a[7];
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [15:0] negOf(logic [15:0] s);
    return 16'(~s + 16'd1);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nRun++;
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int ones, pOnes, zerosQ0;
    logic [7:0] hAddr;
    logic hSin, hCos;

    // R1: reset state
    repeat (3) step();
    rst = 1'b0;
    step();
    check(addr == 8'd0, "R1 addr after reset", addr, 0);
    check(wrapStrobe == 1'b0, "R1 wrapStrobe after reset", wrapStrobe, 0);
    check(pAddr == 8'd0, "R1 port instance addr", pAddr, 0);

    // Full-period sweep: R2, R4, R5, R6, R7, R9
    en = 1'b1;
    ones = 0; pOnes = 0; zerosQ0 = 0;
    for (int i = 0; i < 256; i++) begin
      check(addr == 8'(i), "R2 address count", addr, i);
      check(sinBit == refBit(DefPat, 8'(i)), "R5 sine bit", sinBit, refBit(DefPat, 8'(i)));
      check(cosBit == refBit(DefPat, 8'(i + 64)), "R6 cosine bit", cosBit, refBit(DefPat, 8'(i + 64)));
      check(pSin == refBit(AltPat, 8'(i)), "R9 port sine bit", pSin, refBit(AltPat, 8'(i)));
      check(pCos == refBit(AltPat, 8'(i + 64)), "R9 port cosine bit", pCos, refBit(AltPat, 8'(i + 64)));
      ones += int'(sinBit);
      pOnes += int'(pSin);
      if (i < 64 && !sinBit) zerosQ0++;
      step();
      check(wrapStrobe == (i == 255), "R4 wrap strobe", wrapStrobe, int'(i == 255));
    end
    check(addr == 8'd0, "R2 wrap to zero", addr, 0);
    check(ones == 128, "R7 period balance default", ones, 128);
    check(pOnes == 128, "R7 period balance port", pOnes, 128);
    check(zerosQ0 == 11, "R7 zero count in first quarter", zerosQ0, 11);

    // R3: hold with enable low
    repeat (37) step();
    en = 1'b0;
    hAddr = addr; hSin = sinBit; hCos = cosBit;
    for (int k = 0; k < 5; k++) begin
      step();
      check(addr == hAddr, "R3 address held", addr, hAddr);
      check(sinBit == hSin && cosBit == hCos, "R3 bits held", {sinBit, cosBit}, {hSin, hCos});
    end

    // R8: sign-select table walk
    for (int v = 0; v < 8; v++) begin
      logic [15:0] s, n;
      s = VecTab[v][31:16];
      n = VecTab[v][15:0];
      check(negOf(s) == n, "R8 vector table", negOf(s), n);
      sampleIn = s;
      #1;
      check(sinProd == (sinBit ? s : n), "R8 sine product", sinProd, sinBit ? s : n);
      check(cosProd == (cosBit ? s : n), "R8 cosine product", cosProd, cosBit ? s : n);
      en = 1'b1;
      step();
      en = 1'b0;
    end

    // R8: most negative sample on a zero reference bit
    sampleIn = 16'sh8000;
    en = 1'b1;
    while (addr != 8'd0) step();
    en = 1'b0;
    #1;
    check(sinBit == 1'b0, "R5 sine bit at address 0", sinBit, 0);
    check(sinProd == 16'sh8000, "R8 most negative wraps", sinProd, 16'sh8000);

    // R4: park at 255 with enable low, strobe only on the real wrap
    en = 1'b1;
    while (addr != 8'd255) step();
    en = 1'b0;
    for (int k = 0; k < 3; k++) begin
      step();
      check(wrapStrobe == 1'b0 && addr == 8'd255, "R4 no strobe while parked", wrapStrobe, 0);
    end
    en = 1'b1;
    step();
    check(addr == 8'd0 && wrapStrobe == 1'b1, "R4 strobe on wrap", wrapStrobe, 1);
    step();
    check(wrapStrobe == 1'b0 && addr == 8'd1, "R4 strobe single cycle", wrapStrobe, 0);

    // R1: mid-run reset with enable high
    repeat (98) step();
    rst = 1'b1;
    step();
    check(addr == 8'd0 && wrapStrobe == 1'b0, "R1 mid-run reset", addr, 0);
    rst = 1'b0;
    step();
    check(addr == 8'd1, "R2 resumes after reset", addr, 1);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule